// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. Four scan signals control it: a test clock, a mode-select line, serial data in and serial data out. A 16-state controller steps on the mode-select line and picks either a 3-bit instruction register or one of three data registers to sit between serial in and serial out. The data registers are a 1-bit bypass stage, a 32-bit identification word and a boundary chain of configurable length. The port has no dedicated test-reset input. The controller returns to its reset state when the chip's power-on reset is low, or when the mode-select line is held high for five test-clock rising edges.

The boundary chain has a parallel capture input from the pins and a parallel drive output. A select line tells the pad logic to drive the chain's update latch instead of the core's own values. A separate force line makes the pads release every core output to high impedance. The scan interface carries no back-pressure: one bit moves on every test-clock edge while the controller sits in a shift state. The serial output changes only on the falling edge. Its enable is low outside the two shift states, so the pad can hold that line at high impedance.

Top module: `scan_tap_ctrl`

## Requirements
- R1: While `por_n` is low, the controller is in the reset state and the instruction is IDCODE (001). `tdo_oe`, `pin_drv_sel`, `core_hiz` and `pin_drv` are all 0.
- R2: From any state, five consecutive rising `tck` edges with `tms` high bring the controller to the reset state and reload IDCODE.
- R3: `tms` and `tdi` are sampled on rising `tck`. `tdo` and `tdo_oe` change only on falling `tck`. `tdo_oe` is 1 exactly in the two shift states, so on the rising edge that enters a shift state the enable is still 0.
- R4: In Capture-IR the instruction shifter loads 001, with the MSB 0 and the two LSBs 01. It shifts out LSB first.
- R5: A shifted instruction becomes active on the rising edge that enters Update-IR. While it is being shifted, and in Exit1-IR, the outputs still follow the old instruction.
- R6: Opcode decode. 000 EXTEST, 010 SAMPLE-Z and 100 SAMPLE/PRELOAD select the boundary chain. 001 IDCODE selects the identification word. 111 and the unused codes 011, 101 and 110 select the bypass stage.
- R7: The bypass stage captures 0 in Capture-DR and delays `tdi` by one shift.
- R8: Under IDCODE, Capture-DR loads the `ID_CODE` parameter, which shifts out LSB first.
- R9: Under any boundary instruction, Capture-DR loads cell i from `pin_in[i]` when bit i of `TIED_MASK` is 1, and loads 1 otherwise. Cell 0 shifts out first.
- R10: On entry to Update-DR under EXTEST or SAMPLE/PRELOAD, `pin_drv` takes the shifted chain. It changes at no other time except power-on reset. `pin_drv_sel` is 1 exactly while EXTEST is active.
- R11: `core_hiz` is 1 exactly while SAMPLE-Z is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Chip power-on reset, active low, asynchronous |
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, steers the controller |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on falling tck |
| tdo_oe | output | 1 | Output enable for the serial-out pad |
| pin_in | input | BSR_LEN | Pin levels captured into the boundary chain |
| pin_drv | output | BSR_LEN | Boundary update latch, driven to pins under EXTEST |
| pin_drv_sel | output | 1 | Pads take `pin_drv` instead of core values |
| core_hiz | output | 1 | Pads force all core outputs to high impedance |

## Verification
The bench builds the block with an 8-cell boundary chain, a tie mask of 0x7E so that the two end cells are unbound, and a fixed 32-bit identification word. These values keep every pin pattern within reach. All 256 pin levels are captured and preloaded. All eight opcodes are loaded, and the length and capture value of each selected path are measured from the serial output. The five-high return to reset is exercised from each of the 16 controller states, each reached by its own mode-select path.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int IR_W = 3;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] { PATH_BYP, PATH_ID, PATH_BSR } dr_path_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPZ   = 3'b010;
  localparam logic [IR_W-1:0] OP_PRELOAD = 3'b100;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  function automatic dr_path_e path_of(input logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPZ, OP_PRELOAD: path_of = PATH_BSR;
      OP_IDCODE:                       path_of = PATH_ID;
      default:                         path_of = PATH_BYP;
    endcase
  endfunction

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      ST_RESET:  tap_next = m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   tap_next = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: tap_next = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: tap_next = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  tap_next = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: tap_next = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: tap_next = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: tap_next = m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: tap_next = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: tap_next = m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: tap_next = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  tap_next = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: tap_next = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: tap_next = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: tap_next = m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: tap_next = m ? ST_SEL_DR : ST_IDLE;
      default:   tap_next = ST_RESET;
    endcase
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       por_n,
  input  logic       tck,
  input  logic       tms,
  output tap_state_e state,
  output tap_state_e nxt
);

  assign nxt = tap_next(state, tms);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state <= ST_RESET;
    else        state <= nxt;
  end

  // R2: five rising edges with tms high always land in the reset state
  a_r2_five_high_reset: assert property (@(posedge tck) disable iff (!por_n)
    (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> (state == ST_RESET));

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
  import scan_tap_pkg::*;
(
  input  logic            por_n,
  input  logic            tck,
  input  logic            tdi,
  input  tap_state_e      state,
  input  tap_state_e      nxt,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_lsb
);

  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_sh <= IR_CAPTURE;
      ir_q  <= OP_IDCODE;
    end else begin
      if (state == ST_CAP_IR)     ir_sh <= IR_CAPTURE;
      else if (state == ST_SH_IR) ir_sh <= {tdi, ir_sh[IR_W-1:1]};

      if (nxt == ST_RESET)        ir_q <= OP_IDCODE;
      else if (nxt == ST_UPD_IR)  ir_q <= ir_sh;
    end
  end

  assign ir_lsb = ir_sh[0];

  // R4: capture loads 001 into the shifter
  a_r4_capture_pattern: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_CAP_IR) |=> (ir_sh == 3'b001));

  // R5: the active instruction moves only when entering Update-IR or reset
  a_r5_ir_update_only: assert property (@(posedge tck) disable iff (!por_n)
    !$stable(ir_q) |-> (state == ST_UPD_IR || state == ST_RESET));

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
  import scan_tap_pkg::*;
#(
  parameter int                   BSR_LEN   = 16,
  parameter logic [ID_W-1:0]      ID_CODE   = 32'h1357_9BDF,
  parameter logic [BSR_LEN-1:0]   TIED_MASK = '1
) (
  input  logic               por_n,
  input  logic               tck,
  input  logic               tdi,
  input  tap_state_e         state,
  input  tap_state_e         nxt,
  input  logic [IR_W-1:0]    ir_q,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic               dr_lsb,
  output logic [BSR_LEN-1:0] bsr_upd
);

  dr_path_e           path;
  logic               byp_q;
  logic [ID_W-1:0]    id_sh;
  logic [BSR_LEN-1:0] bsr_sh;
  logic [BSR_LEN-1:0] bsr_cap;
  logic               upd_ok;

  assign path   = path_of(ir_q);
  assign upd_ok = (ir_q == OP_EXTEST) || (ir_q == OP_PRELOAD);

  // per-cell capture source: bound cells read the pin, unbound ones read 1
  for (genvar c = 0; c < BSR_LEN; c++) begin : g_cell
    if (TIED_MASK[c]) begin : g_pin
      assign bsr_cap[c] = pin_in[c];
    end else begin : g_one
      assign bsr_cap[c] = 1'b1;
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      byp_q   <= 1'b0;
      id_sh   <= '0;
      bsr_sh  <= '0;
      bsr_upd <= '0;
    end else begin
      if (state == ST_CAP_DR) begin
        case (path)
          PATH_BYP: byp_q  <= 1'b0;
          PATH_ID:  id_sh  <= ID_CODE;
          default:  bsr_sh <= bsr_cap;
        endcase
      end else if (state == ST_SH_DR) begin
        case (path)
          PATH_BYP: byp_q  <= tdi;
          PATH_ID:  id_sh  <= {tdi, id_sh[ID_W-1:1]};
          default:  bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
        endcase
      end
      if (nxt == ST_UPD_DR && upd_ok) bsr_upd <= bsr_sh;
    end
  end

  always_comb begin
    case (path)
      PATH_BYP: dr_lsb = byp_q;
      PATH_ID:  dr_lsb = id_sh[0];
      default:  dr_lsb = bsr_sh[0];
    endcase
  end

  // R7: bypass stage holds 0 right after capture
  a_r7_bypass_zero: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_CAP_DR && path == PATH_BYP) |=> (byp_q == 1'b0));

  // R10: the drive latch moves only on entry to Update-DR
  a_r10_latch_on_update: assert property (@(posedge tck) disable iff (!por_n)
    !$stable(bsr_upd) |-> (state == ST_UPD_DR));

endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
  import scan_tap_pkg::*;
#(
  parameter int                 BSR_LEN   = 16,
  parameter logic [31:0]        ID_CODE   = 32'h1357_9BDF,
  parameter logic [BSR_LEN-1:0] TIED_MASK = '1
) (
  input  logic               por_n,
  input  logic               tck,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic [BSR_LEN-1:0] pin_drv,
  output logic               pin_drv_sel,
  output logic               core_hiz
);

  tap_state_e      state;
  tap_state_e      nxt;
  logic [IR_W-1:0] ir_q;
  logic            ir_lsb;
  logic            dr_lsb;

  scan_tap_fsm u_fsm (
    .por_n (por_n),
    .tck   (tck),
    .tms   (tms),
    .state (state),
    .nxt   (nxt)
  );

  scan_tap_ir u_ir (
    .por_n  (por_n),
    .tck    (tck),
    .tdi    (tdi),
    .state  (state),
    .nxt    (nxt),
    .ir_q   (ir_q),
    .ir_lsb (ir_lsb)
  );

  scan_tap_dr #(
    .BSR_LEN   (BSR_LEN),
    .ID_CODE   (ID_CODE),
    .TIED_MASK (TIED_MASK)
  ) u_dr (
    .por_n   (por_n),
    .tck     (tck),
    .tdi     (tdi),
    .state   (state),
    .nxt     (nxt),
    .ir_q    (ir_q),
    .pin_in  (pin_in),
    .dr_lsb  (dr_lsb),
    .bsr_upd (pin_drv)
  );

  // serial output is retimed to the falling edge
  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
      tdo    <= (state == ST_SH_IR) ? ir_lsb : dr_lsb;
    end
  end

  assign pin_drv_sel = (ir_q == OP_EXTEST);
  assign core_hiz    = (ir_q == OP_SAMPZ);

  // R3: at each rising edge the enable reflects the state held since the last edge
  a_r3_oe_window: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe == (state == ST_SH_IR || state == ST_SH_DR));

  // R11/R10: the pads are never asked to drive scan values and float at once
  a_r11_hiz_excl: assert property (@(posedge tck) disable iff (!por_n)
    !(core_hiz && pin_drv_sel));

endmodule

// File: tb/scan_tap_ctrl_tb.sv
module scan_tap_ctrl_tb;

  localparam int          CLK_PERIOD = 10;
  localparam int          BL         = 8;
  localparam logic [31:0] IDV        = 32'h2B3C_4D5F;
  localparam logic [7:0]  TMASK      = 8'h7E;

  logic          por_n = 1'b0;
  logic          tck   = 1'b0;
  logic          tms   = 1'b1;
  logic          tdi   = 1'b0;
  logic          tdo, tdo_oe, pin_drv_sel, core_hiz;
  logic [BL-1:0] pin_in = '0;
  logic [BL-1:0] pin_drv;

  int total = 0;
  int bad   = 0;
  logic pre_hiz, pre_sel;

  always #(CLK_PERIOD/2) tck = ~tck;

  scan_tap_ctrl #(.BSR_LEN(BL), .ID_CODE(IDV), .TIED_MASK(TMASK)) u_dut (
    .por_n(por_n), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_in(pin_in), .pin_drv(pin_drv), .pin_drv_sel(pin_drv_sel), .core_hiz(core_hiz)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d, output logic o, output logic oe);
    @(negedge tck); #1;
    o = tdo; oe = tdo_oe;
    tms = m; tdi = d;
    @(posedge tck);
  endtask

  task automatic step(input logic m);
    logic o, oe;
    tick(m, 1'b0, o, oe);
  endtask

  task automatic walk(input string s);
    for (int i = 0; i < s.len(); i++) step(s[i] == "1");
  endtask

  // starts and ends in Run-Test/Idle
  task automatic scan(input bit is_ir, input int n, input logic [63:0] din, output logic [63:0] dout);
    logic o, oe;
    bit oe_ok = 1'b1;
    dout = '0;
    step(1'b1);
    if (is_ir) step(1'b1);
    step(1'b0);
    step(1'b0);
    #1;
    check(tdo_oe == 1'b0, "R3 enable before falling edge", tdo_oe, 0);
    for (int i = 0; i < n; i++) begin
      tick(i == n-1, din[i], o, oe);
      dout[i] = o;
      if (oe !== 1'b1) oe_ok = 1'b0;
    end
    pre_hiz = core_hiz;
    pre_sel = pin_drv_sel;
    step(1'b1);
    step(1'b0);
    check(oe_ok, "R3 enable during shift", oe_ok, 1);
  endtask

  task automatic load_op(input logic [2:0] op);
    logic [63:0] r;
    logic ohiz, osel;
    ohiz = core_hiz; osel = pin_drv_sel;
    scan(1'b1, 3, {61'd0, op}, r);
    check(r[2:0] == 3'b001, "R4 capture-IR value", r[2:0], 3'b001);
    check(pre_hiz == ohiz && pre_sel == osel, "R5 old instruction while shifting",
          {pre_hiz, pre_sel}, {ohiz, osel});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] r, e, pat;
    logic [7:0]  cap;
    logic o, oe;
    string paths [16];
    paths = '{"", "1", "10", "100", "101", "1010", "10101", "1011",
              "11", "110", "1100", "1101", "11010", "110101", "11011", "111"};
    pat = 64'h0000_C3A5_96F0_1E2D;

    // R1: power-on state
    repeat (3) @(posedge tck);
    #1;
    check(tdo_oe == 0 && core_hiz == 0 && pin_drv_sel == 0 && pin_drv == 0,
          "R1 reset outputs", {tdo_oe, core_hiz, pin_drv_sel, pin_drv}, 0);
    @(negedge tck); por_n = 1'b1;
    step(1'b1); step(1'b0);
    #1;
    check(tdo_oe == 0, "R3 idle enable low", tdo_oe, 0);

    // R1/R8: IDCODE is the default instruction
    scan(1'b0, 32, 64'd0, r);
    check(r[31:0] == IDV, "R8 id word after power-up", r[31:0], IDV);

    // R6/R7/R8/R9/R10/R11: every opcode
    pin_in = 8'h96;
    for (int op = 0; op < 8; op++) begin
      load_op(op[2:0]);
      check(pin_drv_sel == (op == 0), "R10 drive select decode", pin_drv_sel, (op == 0));
      check(core_hiz == (op == 2), "R11 high impedance decode", core_hiz, (op == 2));
      scan(1'b0, 48, pat, r);
      cap = pin_in | ~TMASK;
      if (op == 1)                       e = {16'd0, pat[15:0], IDV};
      else if (op == 0 || op == 2 || op == 4) e = {16'd0, pat[39:0], cap};
      else                               e = {16'd0, pat[46:0], 1'b0};
      check(r == e, (op == 1) ? "R8 id path" : ((op == 0 || op == 2 || op == 4) ? "R9 chain path" : "R7 bypass path"), r, e);
      check(r == e, "R6 path length", r, e);
    end

    // R9/R10: all pin patterns under SAMPLE/PRELOAD
    load_op(3'b100);
    for (int p = 0; p < 256; p++) begin
      pin_in = p[7:0];
      scan(1'b0, 8, {56'd0, ~p[7:0]}, r);
      cap = p[7:0] | ~TMASK;
      check(r[7:0] == cap, "R9 capture pins", r[7:0], cap);
      check(pin_drv == ~p[7:0] && pin_drv_sel == 0, "R10 preload latch",
            {pin_drv_sel, pin_drv}, {1'b0, ~p[7:0]});
    end
    load_op(3'b000);
    check(pin_drv_sel == 1 && pin_drv == 8'h00, "R10 extest drives preload",
          {pin_drv_sel, pin_drv}, {1'b1, 8'h00});
    scan(1'b0, 8, 64'h5A, r);
    check(pin_drv == 8'h5A, "R10 extest update", pin_drv, 8'h5A);

    // R2: five highs from every state
    for (int s = 0; s < 16; s++) begin
      load_op(3'b010);
      check(core_hiz == 1, "R11 sample-z active", core_hiz, 1);
      walk(paths[s]);
      repeat (5) step(1'b1);
      #1;
      check(core_hiz == 0 && pin_drv_sel == 0, "R2 reset after five highs",
            {core_hiz, pin_drv_sel}, 0);
      step(1'b0);
      scan(1'b0, 32, 64'd0, r);
      check(r[31:0] == IDV, "R2 idcode reloaded", r[31:0], IDV);
    end

    tick(1'b0, 1'b0, o, oe);
    check(oe == 0, "R3 idle enable after runs", oe, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule